// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block drives the command pins of a DDR3-class memory device from the end of reset up to normal operation. When its synchronous reset is released, it raises CKE and waits out the exit-reset interval. It then programs the four mode registers in a fixed order, waits for the mode update delay, and issues a long ZQ calibration. Once the calibration time and the DLL lock time have both run out, it raises a done flag. A memory controller uses that flag to pass the command bus over to its normal scheduler.

Every wait is fixed at elaboration. Each one is the larger of a minimum clock count and a nanosecond limit converted to clocks at the configured clock period, with the conversion rounded up. The mode-register contents are parameters. On every cycle that carries no command, the block drives NOP.

Top module: `dram_init_seq`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the outputs after that edge are `cke_o`=0, `cmd_o`=NOP (4'b0111), `ba_o`=0, `addr_o`=0 and `done_o`=0. This holds whatever state the sequence was in.
- R2: `cke_o` rises on the first edge after reset is released and stays high. No command other than NOP is issued until T_XPR cycles after that rise.
- R3: `cmd_o` is a 4-bit vector {cs_n, ras_n, cas_n, we_n}. Mode-register writes use the code 4'b0000 and are issued in the order MR2, MR3, MR1, MR0. Each write drives its register number on `ba_o` and its parameter value on `addr_o`.
- R4: Consecutive mode-register writes are exactly T_MRD cycles apart.
- R5: The MR0 write always has `addr_o[8]` (DLL reset) set, even when the MR0 parameter has that bit clear.
- R6: The long ZQ calibration uses the code 4'b0110 with `addr_o[10]`=1 and `ba_o`=0. It is issued exactly T_MOD cycles after the MR0 write.
- R7: `done_o` rises at cycle max(ZQ + T_ZQINIT, MR0 + T_DLLK) and then stays high until the next reset.
- R8: Every cycle that carries no command drives NOP with `ba_o` and `addr_o` at zero.
- R9: Each wait is the larger of its clock minimum and ceil(ns·1000 / TCK_PS). T_XPR uses tRFC + 10 ns with a 5-clock minimum. T_MOD uses 15 ns with a 12-clock minimum. T_ZQINIT uses 640 ns with a 512-clock minimum.
- R10: After `done_o` rises, the command bus stays at NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_o | output | 1 | Clock enable to the device |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row/column address |
| done_o | output | 1 | Initialization complete |

## Verification
The sequence has no inputs apart from reset. Any fault in the internal state therefore shows up at the ports as a command that appears on the wrong cycle, carries the wrong bank or address, or never appears. The bench compares every cycle after reset release against a timeline it computes itself. A counter off by one shows up within one cycle of the first affected command. A wrong register order shows up on the first write. A fault in the DLL or ZQ join shows up on the cycle when done should rise. Random mid-sequence resets show whether every state returns to idle within one edge.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_ZQC = 4'b0110,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        ST_RST,
        ST_XPR,
        ST_MRS,
        ST_MOD,
        ST_ZQW,
        ST_DONE
    } state_e;

    localparam int DLL_RST_BIT = 8;
    localparam int ZQ_LONG_BIT = 10;

    function automatic int ns_to_cyc(input int ns, input int tck_ps);
        return (ns * 1000 + tck_ps - 1) / tck_ps;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // write slot -> mode register number (MR2, MR3, MR1, MR0)
    function automatic logic [1:0] mr_of_slot(input logic [1:0] slot);
        case (slot)
            2'd0:    return 2'd2;
            2'd1:    return 2'd3;
            2'd2:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    // R9
    timer_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !zero_o);
endmodule

// File: rtl/dram_init_mrsel.sv
module dram_init_mrsel
    import dram_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3,
    parameter logic [ADDR_W-1:0] MR0_VAL = '0,
    parameter logic [ADDR_W-1:0] MR1_VAL = '0,
    parameter logic [ADDR_W-1:0] MR2_VAL = '0,
    parameter logic [ADDR_W-1:0] MR3_VAL = '0
) (
    input  logic [1:0]        slot,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [1:0] mr_num;

    assign mr_num = mr_of_slot(slot);
    assign ba_o   = BA_W'(mr_num);

    always_comb begin
        case (mr_num)
            2'd0: begin
                addr_o = MR0_VAL;
                addr_o[DLL_RST_BIT] = 1'b1;
            end
            2'd1:    addr_o = MR1_VAL;
            2'd2:    addr_o = MR2_VAL;
            default: addr_o = MR3_VAL;
        endcase
    end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int TCK_PS        = 1250,
    parameter int ADDR_W        = 14,
    parameter int BA_W          = 3,
    parameter int RFC_NS        = 110,
    parameter int XPR_EXTRA_NS  = 10,
    parameter int XPR_MIN_CK    = 5,
    parameter int MRD_CK        = 4,
    parameter int MOD_NS        = 15,
    parameter int MOD_MIN_CK    = 12,
    parameter int ZQINIT_NS     = 640,
    parameter int ZQINIT_MIN_CK = 512,
    parameter int DLLK_CK       = 512,
    parameter logic [ADDR_W-1:0] MR0_VAL = 14'h0070,
    parameter logic [ADDR_W-1:0] MR1_VAL = 14'h0044,
    parameter logic [ADDR_W-1:0] MR2_VAL = 14'h0018,
    parameter logic [ADDR_W-1:0] MR3_VAL = 14'h0000
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke_o,
    output logic [3:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam int T_XPR  = max_int(XPR_MIN_CK, ns_to_cyc(RFC_NS + XPR_EXTRA_NS, TCK_PS));
    localparam int T_MRD  = MRD_CK;
    localparam int T_MOD  = max_int(MOD_MIN_CK, ns_to_cyc(MOD_NS, TCK_PS));
    localparam int T_ZQ   = max_int(ZQINIT_MIN_CK, ns_to_cyc(ZQINIT_NS, TCK_PS));
    localparam int T_DLLK = DLLK_CK;
    localparam int T_MAX  = max_int(max_int(T_XPR, T_MOD), max_int(T_ZQ, T_DLLK));
    localparam int CNT_W  = $clog2(T_MAX + 1);

    state_e            st;
    logic [1:0]        slot;
    logic              seq_zero, dll_zero;
    logic              ld_seq, ld_dll;
    logic [CNT_W-1:0]  ld_val;
    logic              issue_mrs, issue_zq;
    logic [BA_W-1:0]   mr_ba;
    logic [ADDR_W-1:0] mr_addr;
    cmd_e              cmd_q;

    dram_init_timer #(.W(CNT_W)) u_seq_tmr (
        .clk(clk), .rst(rst), .load(ld_seq), .load_val(ld_val), .zero_o(seq_zero)
    );

    dram_init_timer #(.W(CNT_W)) u_dll_tmr (
        .clk(clk), .rst(rst), .load(ld_dll),
        .load_val(CNT_W'(T_DLLK - 1)), .zero_o(dll_zero)
    );

    dram_init_mrsel #(
        .ADDR_W(ADDR_W), .BA_W(BA_W),
        .MR0_VAL(MR0_VAL), .MR1_VAL(MR1_VAL), .MR2_VAL(MR2_VAL), .MR3_VAL(MR3_VAL)
    ) u_mrsel (
        .slot(slot), .ba_o(mr_ba), .addr_o(mr_addr)
    );

    always_comb begin
        issue_mrs = ((st == ST_XPR) || (st == ST_MRS)) && seq_zero;
        issue_zq  = (st == ST_MOD) && seq_zero;
        ld_seq    = 1'b0;
        ld_dll    = 1'b0;
        ld_val    = '0;
        if (st == ST_RST) begin
            ld_seq = 1'b1;
            ld_val = CNT_W'(T_XPR - 1);
        end else if (issue_mrs) begin
            ld_seq = 1'b1;
            if (slot == 2'd3) begin
                ld_val = CNT_W'(T_MOD - 1);
                ld_dll = 1'b1;
            end else begin
                ld_val = CNT_W'(T_MRD - 1);
            end
        end else if (issue_zq) begin
            ld_seq = 1'b1;
            ld_val = CNT_W'(T_ZQ - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_RST;
            slot   <= 2'd0;
            cke_o  <= 1'b0;
            cmd_q  <= CMD_NOP;
            ba_o   <= '0;
            addr_o <= '0;
            done_o <= 1'b0;
        end else begin
            cmd_q  <= CMD_NOP;
            ba_o   <= '0;
            addr_o <= '0;
            case (st)
                ST_RST: begin
                    cke_o <= 1'b1;
                    st    <= ST_XPR;
                end
                ST_XPR, ST_MRS: begin
                    if (issue_mrs) begin
                        cmd_q  <= CMD_MRS;
                        ba_o   <= mr_ba;
                        addr_o <= mr_addr;
                        slot   <= slot + 2'd1;
                        st     <= (slot == 2'd3) ? ST_MOD : ST_MRS;
                    end
                end
                ST_MOD: begin
                    if (issue_zq) begin
                        cmd_q  <= CMD_ZQC;
                        addr_o[ZQ_LONG_BIT] <= 1'b1;
                        st     <= ST_ZQW;
                    end
                end
                ST_ZQW: begin
                    if (seq_zero && dll_zero) begin
                        done_o <= 1'b1;
                        st     <= ST_DONE;
                    end
                end
                default: done_o <= 1'b1;
            endcase
        end
    end

    assign cmd_o = cmd_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!cke_o && cmd_o == CMD_NOP && !done_o && ba_o == '0 && addr_o == '0));
    // R2
    cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_NOP) |-> cke_o);
    // R8
    single_cmd_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_NOP) |=> (cmd_o == CMD_NOP));
    // R5
    mr0_dll_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_MRS && ba_o == '0) |-> addr_o[DLL_RST_BIT]);
    // R6
    zq_long_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ZQC) |-> (addr_o[ZQ_LONG_BIT] && ba_o == '0));
    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);
    // R10
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cmd_o == CMD_NOP));
endmodule

// File: tb/dram_init_seq_tb.sv
`timescale 1ns/1ps
module dram_init_seq_tb;
    localparam int TCK_PS = 1250;
    localparam int ADDR_W = 14;
    localparam int BA_W   = 3;
    localparam logic [ADDR_W-1:0] M0 = 14'h0070;
    localparam logic [ADDR_W-1:0] M1 = 14'h0044;
    localparam logic [ADDR_W-1:0] M2 = 14'h0018;
    localparam logic [ADDR_W-1:0] M3 = 14'h0203;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cke;
    logic [3:0]        cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic              done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dram_init_seq #(
        .TCK_PS(TCK_PS), .ADDR_W(ADDR_W), .BA_W(BA_W),
        .MR0_VAL(M0), .MR1_VAL(M1), .MR2_VAL(M2), .MR3_VAL(M3)
    ) u_dut (
        .clk(clk), .rst(rst), .cke_o(cke), .cmd_o(cmd),
        .ba_o(ba), .addr_o(addr), .done_o(done)
    );

    function automatic int cdiv(input int ns);
        int c = 0;
        while (c * TCK_PS < ns * 1000) c++;
        return c;
    endfunction
    function automatic int bigger(input int a, input int b);
        if (a >= b) return a;
        return b;
    endfunction

    // R9 waits recomputed in the bench
    int e_xpr, e_mod, e_zq, e_m0, e_zqc, e_done;

    task automatic check(input string tag, input logic [3:0] ecmd, input logic [BA_W-1:0] eba,
                         input logic [ADDR_W-1:0] ead, input logic ecke, input logic edone, input int k);
        total++;
        if (cmd !== ecmd || ba !== eba || addr !== ead || cke !== ecke || done !== edone) begin
            bad++;
            $display("FAIL %s k=%0d: cke/cmd/ba/addr/done actual %b/%b/%0d/%h/%b expected %b/%b/%0d/%h/%b",
                     tag, k, cke, cmd, ba, addr, done, ecke, ecmd, eba, ead, edone);
        end
    endtask

    task automatic check_k(input int k);
        logic [3:0] c = 4'b0111;
        logic [BA_W-1:0] b = '0;
        logic [ADDR_W-1:0] a = '0;
        string tag = (k < e_xpr) ? "R2" : ((k >= e_done) ? "R10 R7" : "R8 R7");
        if (k == e_xpr)               begin c = 4'b0000; b = 2; a = M2;  tag = "R2 R3 R9"; end
        else if (k == e_xpr + 4)      begin c = 4'b0000; b = 3; a = M3;  tag = "R3 R4"; end
        else if (k == e_xpr + 8)      begin c = 4'b0000; b = 1; a = M1;  tag = "R3 R4"; end
        else if (k == e_m0)           begin c = 4'b0000; b = 0; a = M0 | 14'h0100; tag = "R3 R4 R5"; end
        else if (k == e_zqc)          begin c = 4'b0110; a = 14'h0400; tag = "R6 R9"; end
        check(tag, c, b, a, 1'b1, k >= e_done, k);
    endtask

    task automatic check_reset(input int k);
        check("R1", 4'b0111, '0, '0, 1'b0, 1'b0, k);
    endtask

    // release reset, follow timeline for n cycles, then reset if abort
    task automatic run(input int n, input bit abort);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_k(k);
        end
        if (abort) begin
            rst = 1'b1;
            @(negedge clk);
            check_reset(n);
        end
    endtask

    initial begin
        e_xpr  = bigger(5, cdiv(110 + 10));
        e_mod  = bigger(12, cdiv(15));
        e_zq   = bigger(512, cdiv(640));
        e_m0   = e_xpr + 12;
        e_zqc  = e_m0 + e_mod;
        e_done = bigger(e_zqc + e_zq, e_m0 + 512);
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset(-1);
        // directed: full sequence plus hold time
        run(e_done + 20, 1'b1);
        // directed corner: reset exactly at the first command and at done
        run(e_xpr + 1, 1'b1);
        run(e_done + 1, 1'b1);
        // random mid-sequence resets
        for (int i = 0; i < 8; i++) begin
            run($urandom_range(0, e_done + 5), 1'b1);
        end
        // final full run to done after aborted runs
        run(e_done + 10, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule